// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Band

This block drives three half-bridges. Each half-bridge gets two low-active lines: a positive-phase line and its antiphase partner. The timing comes from two triangle counters that advance on a count-enable tick from an external prescaler. Counter B sweeps from zero up to the half-carrier value and back down. Counter A runs the same sweep shifted upward by the dead-time value, so it moves between the dead time and the upper limit (half carrier plus dead time). The positive line of a phase switches when counter B passes that phase's duty value. The antiphase line switches when counter A passes the same value. Because A leads B by exactly the dead time, the two lines of a pair cannot be active together.

The block also produces a carrier-synchronous toggle line and single-cycle strobes at the carrier peak and trough. The peak strobe is meant as the once-per-carrier interrupt request. The configuration inputs (dead time, half carrier, upper limit) are expected to hold still while the block runs. Counter A loads the dead-time value during reset. Duty values may change at any time and act directly, without buffering. A typical setup is dead time 40, half carrier 2000, upper limit 2040 and duty 1020 on a 10 MHz tick. That gives a 2.5 kHz carrier with 4 µs of dead band.

Top module: `cpwm3_deadband`

## Requirements
- R1: While reset is asserted, and after it until the first tick, every PWM line is high (inactive), the toggle line is 1 and both strobes are 0.
- R2: Counters advance only on ticks. Counter B starts at 0, rises to the half-carrier value H, then falls back to 0. Counter A starts at the dead time D and stays at B + D. The carrier period is therefore 2·H ticks. The outputs below depend only on the tick count n since reset.
- R3: A positive-phase line and its antiphase line are never low at the same time.
- R4: For a duty value C with 0 < C < upper limit: on the tick where counter B equals C and steps upward, the positive line goes low. On the tick where B equals C and steps downward, it goes high.
- R5: For D < C < upper limit: on the tick where counter A equals C and steps upward, the antiphase line goes high. On the tick where A equals C and steps downward, it goes low.
- R6: A duty of 0 forces the positive line low and the antiphase line high from the first tick on.
- R7: A duty equal to or above the upper limit forces the positive line high and the antiphase line low from the first tick on.
- R8: The peak strobe pulses for one clock after the tick that turns counter A down at the upper limit. The trough strobe pulses for one clock after the tick that turns A up at D. The start of counting is not a trough. Both strobes are 0 after clocks without a tick.
- R9: The toggle line inverts on every peak and every trough and holds its value otherwise.
- R10: With the tick low, no output changes.
- R11: A duty of 1 to D keeps the antiphase line high throughout. A duty equal to H gives a positive line that stays high, while the antiphase line is high for 2·D ticks around each peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the prescaler |
| deadTime | input | CNT_W | Dead time D, also counter A start value |
| halfCarrier | input | CNT_W | Half carrier period H (counter B top) |
| upperLimit | input | CNT_W | Counter A top, H + D |
| duty | input | PHASES×CNT_W | Per-phase compare values |
| pwmPos | output | PHASES | Positive-phase lines, low active |
| pwmNeg | output | PHASES | Antiphase lines, low active |
| carrierToggle | output | 1 | Toggles at each peak and trough |
| peakEvt | output | 1 | Peak strobe |
| troughEvt | output | 1 | Trough strobe |

## Verification
Every output is a register that updates on the clock edge where the tick is sampled high, using the counter values held before that edge. A result caused by the n-th tick is therefore visible after that edge, and the strobes last only until the next edge. The bench drives the tick on falling edges and counts the ticks it has issued. It compares every output on the falling edge that follows each clock. Its expectations come from closed-form triangle positions for that tick count.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam logic LVL_ON  = 1'b0;
  localparam logic LVL_OFF = 1'b1;

  // strobes from the counter control to the output datapath
  typedef struct packed {
    logic step;    // tick accepted this clock
    logic aRise;   // counter A steps upward on this tick
    logic bRise;   // counter B steps upward on this tick
    logic peak;    // counter A turns at its upper limit
    logic trough;  // counter A turns at the dead-time floor
  } cpwmStrobe_t;

endpackage

// File: rtl/cpwm_counters.sv
module cpwm_counters
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  deadTime,
  input  logic [CNT_W-1:0]  halfCarrier,
  input  logic [CNT_W-1:0]  upperLimit,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output cpwmStrobe_t       strb
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic dirAUp, dirBUp;
  logic aTop, aFloor, bTop, bFloor;
  logic aStepUp, bStepUp;

  always_comb begin
    aTop    = dirAUp  && (cntA >= upperLimit);
    aFloor  = !dirAUp && (cntA <= deadTime);
    bTop    = dirBUp  && (cntB >= halfCarrier);
    bFloor  = !dirBUp && (cntB == ZERO);

    if (aTop)        aStepUp = 1'b0;
    else if (aFloor) aStepUp = 1'b1;
    else             aStepUp = dirAUp;

    if (bTop)        bStepUp = 1'b0;
    else if (bFloor) bStepUp = 1'b1;
    else             bStepUp = dirBUp;

    strb.step   = tick;
    strb.aRise  = aStepUp;
    strb.bRise  = bStepUp;
    strb.peak   = aTop;
    strb.trough = aFloor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntA   <= deadTime;
      cntB   <= ZERO;
      dirAUp <= 1'b1;
      dirBUp <= 1'b1;
    end else if (tick) begin
      cntA   <= aStepUp ? cntA + ONE : cntA - ONE;
      cntB   <= bStepUp ? cntB + ONE : cntB - ONE;
      dirAUp <= aStepUp;
      dirBUp <= bStepUp;
    end
  end

endmodule

// File: rtl/cpwm_phase_out.sv
module cpwm_phase_out
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cpwmStrobe_t       strb,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  input  logic [CNT_W-1:0]  duty,
  input  logic [CNT_W-1:0]  upperLimit,
  output logic              posOut,
  output logic              negOut
);

  logic posNext, negNext;

  always_comb begin
    posNext = posOut;
    negNext = negOut;

    // counter B moves the positive line
    if (cntB == duty) posNext = strb.bRise ? LVL_ON : LVL_OFF;
    // counter A moves the antiphase line
    if (cntA == duty) negNext = strb.aRise ? LVL_OFF : LVL_ON;

    // pinned levels at the ends of the duty range
    if (duty == '0) begin
      posNext = LVL_ON;
      negNext = LVL_OFF;
    end else if (duty >= upperLimit) begin
      posNext = LVL_OFF;
      negNext = LVL_ON;
    end

    // shoot-through guard for duty changes in mid-sweep
    if (posNext == LVL_ON && negNext == LVL_ON) posNext = LVL_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posOut <= LVL_OFF;
      negOut <= LVL_OFF;
    end else if (strb.step) begin
      posOut <= posNext;
      negOut <= negNext;
    end
  end

endmodule

// File: rtl/cpwm_carrier_sync.sv
module cpwm_carrier_sync
  import cpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cpwmStrobe_t strb,
  output logic        carrierToggle,
  output logic        peakEvt,
  output logic        troughEvt
);

  logic hitPeak, hitTrough;

  always_comb begin
    hitPeak   = strb.step && strb.peak;
    hitTrough = strb.step && strb.trough;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrierToggle <= 1'b1;
      peakEvt       <= 1'b0;
      troughEvt     <= 1'b0;
    end else begin
      peakEvt   <= hitPeak;
      troughEvt <= hitTrough;
      if (hitPeak || hitTrough) carrierToggle <= !carrierToggle;
    end
  end

endmodule

// File: rtl/cpwm3_deadband.sv
module cpwm3_deadband
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [CNT_W-1:0]              deadTime,
  input  logic [CNT_W-1:0]              halfCarrier,
  input  logic [CNT_W-1:0]              upperLimit,
  input  logic [PHASES-1:0][CNT_W-1:0]  duty,
  output logic [PHASES-1:0]             pwmPos,
  output logic [PHASES-1:0]             pwmNeg,
  output logic                          carrierToggle,
  output logic                          peakEvt,
  output logic                          troughEvt
);

  logic [CNT_W-1:0] cntA, cntB;
  cpwmStrobe_t      strb;

  cpwm_counters #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .deadTime    (deadTime),
    .halfCarrier (halfCarrier),
    .upperLimit  (upperLimit),
    .cntA        (cntA),
    .cntB        (cntB),
    .strb        (strb)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    cpwm_phase_out #(.CNT_W(CNT_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb       (strb),
      .cntA       (cntA),
      .cntB       (cntB),
      .duty       (duty[p]),
      .upperLimit (upperLimit),
      .posOut     (pwmPos[p]),
      .negOut     (pwmNeg[p])
    );
  end

  cpwm_carrier_sync u_sync (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .carrierToggle (carrierToggle),
    .peakEvt       (peakEvt),
    .troughEvt     (troughEvt)
  );

endmodule

// File: rtl/cpwm3_deadband_chk.sv
module cpwm3_deadband_chk #(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic [CNT_W-1:0]              upperLimit,
  input logic [PHASES-1:0][CNT_W-1:0]  duty,
  input logic [PHASES-1:0]             pwmPos,
  input logic [PHASES-1:0]             pwmNeg,
  input logic                          carrierToggle,
  input logic                          peakEvt,
  input logic                          troughEvt
);

  AST_PAIR_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pwmPos) & (~pwmNeg)) == '0); // R3

  AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(peakEvt && troughEvt)); // R8

  AST_TOGGLE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (peakEvt || troughEvt) |-> (carrierToggle != $past(carrierToggle))); // R9

  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(peakEvt || troughEvt) |-> $stable(carrierToggle)); // R9

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick)) |-> ($stable(pwmPos) && $stable(pwmNeg) && !peakEvt && !troughEvt)); // R10

  for (genvar i = 0; i < PHASES; i++) begin : g_pin
    AST_ZERO_DUTY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tick) && $past(duty[i]) == '0) |-> (!pwmPos[i] && pwmNeg[i])); // R6

    AST_FULL_DUTY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tick) && $past(duty[i]) >= $past(upperLimit)) |-> (pwmPos[i] && !pwmNeg[i])); // R7
  end

endmodule

bind cpwm3_deadband cpwm3_deadband_chk #(.CNT_W(CNT_W), .PHASES(PHASES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .upperLimit    (upperLimit),
  .duty          (duty),
  .pwmPos        (pwmPos),
  .pwmNeg        (pwmNeg),
  .carrierToggle (carrierToggle),
  .peakEvt       (peakEvt),
  .troughEvt     (troughEvt)
);

// File: tb/tb_cpwm3_deadband.sv
module tb_cpwm3_deadband;

  localparam int CNT_W  = 16;
  localparam int PHASES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [CNT_W-1:0] deadTime = '0, halfCarrier = '0, upperLimit = '0;
  logic [PHASES-1:0][CNT_W-1:0] duty = '0;
  logic [PHASES-1:0] pwmPos, pwmNeg;
  logic carrierToggle, peakEvt, troughEvt;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int dtV, hV, ulV;
  logic lastTick = 1'b0;
  logic expTog = 1'b1;
  int peakSeen, troughSeen;
  bit done = 0;

  always #10 clk = ~clk;

  cpwm3_deadband #(.CNT_W(CNT_W), .PHASES(PHASES)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .deadTime(deadTime), .halfCarrier(halfCarrier), .upperLimit(upperLimit),
    .duty(duty), .pwmPos(pwmPos), .pwmNeg(pwmNeg),
    .carrierToggle(carrierToggle), .peakEvt(peakEvt), .troughEvt(troughEvt)
  );

  function automatic logic expPos(int cnt, int c);
    int m;
    if (cnt == 0) return 1'b1;
    if (c == 0) return 1'b0;
    if (c >= ulV) return 1'b1;
    m = cnt % (2 * hV);
    return (m >= c + 1 && m <= 2 * hV - c) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic expNeg(int cnt, int c);
    int m, cs;
    if (cnt == 0) return 1'b1;
    if (c == 0) return 1'b1;
    if (c >= ulV) return 1'b0;
    if (c <= dtV) return 1'b1;
    cs = c - dtV;
    if (cnt <= cs) return 1'b1;
    m = cnt % (2 * hV);
    return (m >= cs + 1 && m <= 2 * hV - cs) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic expPeak(int cnt, logic wasTick);
    return wasTick && cnt >= 1 && ((cnt - 1) % (2 * hV)) == hV;
  endfunction

  function automatic logic expTrough(int cnt, logic wasTick);
    return wasTick && cnt > 1 && ((cnt - 1) % (2 * hV)) == 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s n=%0d actual=%0d expected=%0d", req, what, n, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    for (int p = 0; p < PHASES; p++) begin
      chk(tag, $sformatf("pos[%0d]", p), int'(pwmPos[p]), int'(expPos(n, int'(duty[p]))));
      chk(tag, $sformatf("neg[%0d]", p), int'(pwmNeg[p]), int'(expNeg(n, int'(duty[p]))));
      chk("R3", $sformatf("pair[%0d] both low", p), int'(!pwmPos[p] && !pwmNeg[p]), 0);
    end
    chk("R8", "peakEvt", int'(peakEvt), int'(expPeak(n, lastTick)));
    chk("R8", "troughEvt", int'(troughEvt), int'(expTrough(n, lastTick)));
    chk("R9", "carrierToggle", int'(carrierToggle), int'(expTog));
  endtask

  task automatic stepTick(logic t, string tag);
    tick = t;
    @(negedge clk);
    if (t) n++;
    lastTick = t;
    if (expPeak(n, lastTick)) begin peakSeen++; expTog = ~expTog; end
    if (expTrough(n, lastTick)) begin troughSeen++; expTog = ~expTog; end
    compareAll(tag);
  endtask

  task automatic applyReset(int dt, int h, int d0, int d1, int d2);
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    dtV = dt; hV = h; ulV = h + dt;
    deadTime = CNT_W'(dt); halfCarrier = CNT_W'(h); upperLimit = CNT_W'(h + dt);
    duty[0] = CNT_W'(d0); duty[1] = CNT_W'(d1); duty[2] = CNT_W'(d2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0; lastTick = 1'b0; expTog = 1'b1; peakSeen = 0; troughSeen = 0;
  endtask

  task automatic testReset();
    applyReset(3, 20, 10, 5, 17);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pos during reset", int'(pwmPos), 7);
    chk("R1", "neg during reset", int'(pwmNeg), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "pos before tick", int'(pwmPos), 7);
    chk("R1", "neg before tick", int'(pwmNeg), 7);
    chk("R1", "toggle", int'(carrierToggle), 1);
    chk("R1", "strobes", int'(peakEvt || troughEvt), 0);
  endtask

  task automatic testMidDuty();
    applyReset(3, 20, 10, 5, 17);
    for (int k = 0; k < 130; k++) stepTick(1'b1, "R4,R5");
    chk("R2", "peaks in 130 ticks", peakSeen, 3);
    chk("R2", "troughs in 130 ticks", troughSeen, 3);
  endtask

  task automatic testPinned();
    applyReset(3, 20, 0, 23, 30);
    for (int k = 0; k < 60; k++) stepTick(1'b1, "R6,R7");
  endtask

  task automatic testEdgeDuties();
    applyReset(3, 20, 3, 20, 2);
    for (int k = 0; k < 90; k++) stepTick(1'b1, "R11");
    chk("R11", "phase2 antiphase stays high", int'(pwmNeg[2]), 1);
    chk("R11", "phase1 positive stays high", int'(pwmPos[1]), 1);
  endtask

  task automatic testGating();
    applyReset(3, 20, 10, 12, 14);
    for (int k = 0; k < 180; k++) stepTick((k % 3) == 2, "R10");
  endtask

  task automatic testReference();
    applyReset(40, 2000, 1020, 1020, 1020);
    for (int k = 0; k < 4100; k++) stepTick(1'b1, "R2");
    chk("R8", "peak count", peakSeen, 1);
    chk("R8", "trough count", troughSeen, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testMidDuty();
    testPinned();
    testEdgeDuties();
    testGating();
    testReference();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule